// File: doc/BRIEF.md
# Peripheral-Paired DMA Channel

This block is a single DMA channel that shuttles data between a moving memory pointer and one fixed peripheral location. Software loads a 24-bit memory pointer, an 8-bit peripheral offset, a 16-bit run length and a control word, then sets the enable bit. After that, each accepted transfer request from the configured trigger source moves exactly one byte or one 16-bit word. The peripheral location is the offset placed under sixteen ones at the top of the 24-bit space.

No register bit sets which way the data goes. The trigger source does. The serial-receive-full source (code 0) and the converter-done source (code 1) pull data from the peripheral into memory. Every other source pushes memory contents out to the peripheral. Each transfer is a read on a simple bus-master port followed by a write of the same data, and both accesses wait for the bus acknowledge. When the run length reaches zero the channel turns itself off and raises its interrupt line.

Top module: `dma_io_chan`

## Requirements
- R1: Each transfer moves one byte when control bit 0 is 0 and one word when it is 1. `bus_word` shows the size on both accesses. In byte mode the upper 8 bits of the written data are zero.
- R2: After each transfer the memory pointer (select 0) moves by 1 for bytes or 2 for words. It moves down when control bit 1 is 1 and up when it is 0, and it wraps modulo 2^24.
- R3: The peripheral access address is always 16'hFFFF placed above the 8-bit offset register (select 1). It stays the same for the whole run.
- R4: The count register (select 2) drops by one at the end of each transfer.
- R5: With trigger source code 0 or 1 the read goes to the peripheral address and the write goes to the memory pointer. For source codes 2 to 7 the read goes to the memory pointer and the write goes to the peripheral address.
- R6: A transfer is one read followed by one write. The write carries the data returned by the read. Each access holds its request, address and direction until `bus_ack` is seen.
- R7: The transfer that brings the count to zero clears the enable bit (control bit 7) and sets `irq` (read back at control bit 8). Requests are then ignored until software re-enables the channel. Any write to the control register clears `irq`.
- R8: A matching request that arrives while a transfer is in progress is held in a one-deep pending slot. It is served right after the current transfer ends.
- R9: A request whose source code differs from control bits 4..2 is ignored, and so is any request while the channel is disabled.
- R10: A software write to a register in the same cycle as a transfer completion takes priority for that register. The completion still updates the other registers.
- R11: After reset all four registers read zero, `irq` is low and no bus access is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Write select: 0 pointer, 1 offset, 2 count, 3 control |
| cfg_wdata | input | 24 | Write data |
| cfg_rsel | input | 2 | Read select, same encoding |
| cfg_rdata | output | 24 | Read data |
| req_valid | input | 1 | Transfer request strobe |
| req_src | input | 3 | Identity of the requesting source |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for write, 0 for read |
| bus_word | output | 1 | Access size, 1 for word |
| bus_addr | output | 24 | Access address |
| bus_wdata | output | 16 | Write data |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Access complete |
| irq | output | 1 | Run-complete interrupt flag |

## Verification
The two functions that can land in the same cycle are a software write to the memory pointer and the pointer advance made when a transfer completes. The bench takes over the bus responder and raises the write acknowledge on the same clock edge as a pointer write. It then reads back the pointer and count, and it also checks that the following transfer reads from the newly written pointer. A second overlap is a request that arrives while the bus is stalled in wait states. That case is judged by counting the accesses logged afterwards.

// File: rtl/dma_io_pkg.sv
package dma_io_pkg;
  localparam int ADDR_W = 24;
  localparam int IO_W   = 8;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 16;
  localparam int SRC_W  = 3;
  localparam int SEL_W  = 2;

  localparam logic [SEL_W-1:0] SEL_MAR  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_IO   = 2'd1;
  localparam logic [SEL_W-1:0] SEL_CNT  = 2'd2;
  localparam logic [SEL_W-1:0] SEL_CTRL = 2'd3;

  localparam logic [SRC_W-1:0] SRC_SER_RX   = 3'd0;
  localparam logic [SRC_W-1:0] SRC_CONV_END = 3'd1;

  typedef struct packed {
    logic             en;
    logic [SRC_W-1:0] src;
    logic             dec;
    logic             word;
  } ctrl_t;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} seq_state_e;

  function automatic logic [ADDR_W-1:0] mar_advance(input logic [ADDR_W-1:0] a,
                                                    input logic dec, input logic word);
    logic [ADDR_W-1:0] step;
    step = word ? ADDR_W'(2) : ADDR_W'(1);
    return dec ? a - step : a + step;
  endfunction

  function automatic logic [ADDR_W-1:0] io_expand(input logic [IO_W-1:0] off);
    return {{(ADDR_W-IO_W){1'b1}}, off};
  endfunction

  function automatic logic src_inbound(input logic [SRC_W-1:0] s);
    return (s == SRC_SER_RX) || (s == SRC_CONV_END);
  endfunction

  function automatic logic [DATA_W-1:0] size_mask(input logic [DATA_W-1:0] d, input logic word);
    return word ? d : {{(DATA_W-8){1'b0}}, d[7:0]};
  endfunction
endpackage

// File: rtl/dma_io_regs.sv
module dma_io_regs
  import dma_io_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [ADDR_W-1:0] wr_data,
  input  logic [SEL_W-1:0]  rd_sel,
  input  logic              xfer_done,
  output logic [ADDR_W-1:0] mar_q,
  output logic [IO_W-1:0]   io_q,
  output logic [CNT_W-1:0]  cnt_q,
  output ctrl_t             ctrl_q,
  output logic              irq_q,
  output logic [ADDR_W-1:0] rd_data,
  output logic              run_end
);
  localparam int CTRL_PAD = ADDR_W - 9;

  logic wr_mar, wr_io, wr_cnt, wr_ctrl;
  assign wr_mar  = wr_en && (wr_sel == SEL_MAR);
  assign wr_io   = wr_en && (wr_sel == SEL_IO);
  assign wr_cnt  = wr_en && (wr_sel == SEL_CNT);
  assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
  assign run_end = xfer_done && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mar_q  <= '0;
      io_q   <= '0;
      cnt_q  <= '0;
      ctrl_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (wr_mar)         mar_q <= wr_data;
      else if (xfer_done) mar_q <= mar_advance(mar_q, ctrl_q.dec, ctrl_q.word);

      if (wr_io) io_q <= wr_data[IO_W-1:0];

      if (wr_cnt)         cnt_q <= wr_data[CNT_W-1:0];
      else if (xfer_done) cnt_q <= cnt_q - CNT_W'(1);

      if (wr_ctrl) begin
        ctrl_q.word <= wr_data[0];
        ctrl_q.dec  <= wr_data[1];
        ctrl_q.src  <= wr_data[2 +: SRC_W];
        ctrl_q.en   <= wr_data[7];
      end else if (run_end) begin
        ctrl_q.en <= 1'b0;
      end

      if (wr_ctrl)      irq_q <= 1'b0;
      else if (run_end) irq_q <= 1'b1;
    end
  end

  always_comb begin
    case (rd_sel)
      SEL_MAR:  rd_data = mar_q;
      SEL_IO:   rd_data = {{(ADDR_W-IO_W){1'b0}}, io_q};
      SEL_CNT:  rd_data = {{(ADDR_W-CNT_W){1'b0}}, cnt_q};
      default:  rd_data = {{CTRL_PAD{1'b0}}, irq_q, ctrl_q.en, 2'b00,
                           ctrl_q.src, ctrl_q.dec, ctrl_q.word};
    endcase
  end

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !wr_cnt |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R4

  AST_MAR_STRIDE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done && !wr_mar |=> ((mar_q - $past(mar_q)) == ADDR_W'(1)) ||
                             ((mar_q - $past(mar_q)) == ADDR_W'(2)) ||
                             (($past(mar_q) - mar_q) == ADDR_W'(1)) ||
                             (($past(mar_q) - mar_q) == ADDR_W'(2))); // R2

  AST_RUN_END: assert property (@(posedge clk) disable iff (!rst_n)
    run_end && !wr_ctrl |=> !ctrl_q.en && irq_q); // R7

  AST_SW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mar |=> mar_q == $past(wr_data)); // R10
endmodule

// File: rtl/dma_io_seq.sv
module dma_io_seq
  import dma_io_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_t             ctrl,
  input  logic [ADDR_W-1:0] mar,
  input  logic [IO_W-1:0]   io_off,
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_word,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              xfer_done
);
  seq_state_e        st_q;
  logic              pend_q, inb_q, word_q;
  logic [ADDR_W-1:0] mem_q, io_q;
  logic [DATA_W-1:0] data_q;

  logic req_hit, start, rd_fin;
  assign req_hit   = req_valid && ctrl.en && (req_src == ctrl.src);
  assign start     = (st_q == ST_IDLE) && ctrl.en && (pend_q || req_hit);
  assign rd_fin    = (st_q == ST_READ) && bus_ack;
  assign xfer_done = (st_q == ST_WRITE) && bus_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      pend_q <= 1'b0;
      inb_q  <= 1'b0;
      word_q <= 1'b0;
      mem_q  <= '0;
      io_q   <= '0;
      data_q <= '0;
    end else begin
      if (!ctrl.en)   pend_q <= 1'b0;
      else if (start) pend_q <= pend_q && req_hit;
      else            pend_q <= pend_q || req_hit;

      case (st_q)
        ST_IDLE: if (start) begin
          st_q   <= ST_READ;
          inb_q  <= src_inbound(ctrl.src);
          word_q <= ctrl.word;
          mem_q  <= mar;
          io_q   <= io_expand(io_off);
        end
        ST_READ: if (rd_fin) begin
          st_q   <= ST_WRITE;
          data_q <= size_mask(bus_rdata, word_q);
        end
        default: if (xfer_done) st_q <= ST_IDLE;
      endcase
    end
  end

  assign bus_req   = (st_q != ST_IDLE);
  assign bus_we    = (st_q == ST_WRITE);
  assign bus_word  = word_q;
  assign bus_addr  = ((st_q == ST_READ) == inb_q) ? io_q : mem_q;
  assign bus_wdata = data_q;

  AST_IO_HIGH_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && (bus_we != inb_q) |-> bus_addr[ADDR_W-1:IO_W] == '1); // R3

  AST_WRITE_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we) |-> $past(bus_req && bus_ack && !bus_we)); // R6

  AST_HOLD_UNTIL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_we)); // R6

  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_req && !ctrl.en |=> !bus_req); // R7
endmodule

// File: rtl/dma_io_chan.sv
module dma_io_chan
  import dma_io_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic [SEL_W-1:0]  cfg_rsel,
  output logic [ADDR_W-1:0] cfg_rdata,
  input  logic              req_valid,
  input  logic [SRC_W-1:0]  req_src,
  output logic              bus_req,
  output logic              bus_we,
  output logic              bus_word,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              irq
);
  logic [ADDR_W-1:0] mar;
  logic [IO_W-1:0]   io_off;
  logic [CNT_W-1:0]  cnt;
  ctrl_t             ctrl;
  logic              xfer_done, run_end;

  dma_io_regs i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
    .rd_sel(cfg_rsel), .xfer_done(xfer_done), .mar_q(mar), .io_q(io_off), .cnt_q(cnt),
    .ctrl_q(ctrl), .irq_q(irq), .rd_data(cfg_rdata), .run_end(run_end)
  );

  dma_io_seq i_seq (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .mar(mar), .io_off(io_off),
    .req_valid(req_valid), .req_src(req_src), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .xfer_done(xfer_done)
  );

  AST_IRQ_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(run_end) && $past(cnt) == CNT_W'(1)); // R7

  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    run_end |=> !bus_req); // R7
endmodule

// File: tb/test_dma_io_chan.sv
module test_dma_io_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [23:0] cfg_wdata = '0;
  logic [1:0]  cfg_rsel = 2'd0;
  logic [23:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [2:0]  req_src = 3'd0;
  logic        bus_req, bus_we, bus_word;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;
  logic        bus_ack = 1'b0;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  bit auto_resp = 1;
  int wait_n = 0;
  int wcnt = 0;
  int log_n = 0;
  logic        log_we   [0:63];
  logic        log_word [0:63];
  logic [23:0] log_addr [0:63];
  logic [15:0] log_data [0:63];

  always #2 clk = ~clk;

  dma_io_chan i_dma_io_chan (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rsel(cfg_rsel), .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_src(req_src),
    .bus_req(bus_req), .bus_we(bus_we), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq(irq)
  );

  function automatic logic [15:0] fdat(input logic [23:0] a);
    return a[15:0] ^ 16'h5A3C ^ {a[23:16], a[23:16]};
  endfunction

  function automatic logic [23:0] exp_mem(input logic [23:0] base, input int k,
                                          input bit dec, input bit word);
    int step;
    step = word ? 2 : 1;
    return dec ? base - 24'(k * step) : base + 24'(k * step);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (auto_resp) begin
        if (bus_ack) begin
          bus_ack = 1'b0;
          wcnt = 0;
        end else if (bus_req) begin
          if (wcnt >= wait_n) begin
            bus_ack = 1'b1;
            bus_rdata = fdat(bus_addr);
            if (log_n < 64) begin
              log_we[log_n]   = bus_we;
              log_word[log_n] = bus_word;
              log_addr[log_n] = bus_addr;
              log_data[log_n] = bus_we ? bus_wdata : fdat(bus_addr);
              log_n++;
            end
          end else begin
            wcnt++;
          end
        end
      end
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [23:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic cfg_read(input logic [1:0] sel, output logic [23:0] d);
    @(negedge clk);
    cfg_rsel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic pulse_req(input int src);
    @(negedge clk);
    req_valid = 1'b1; req_src = 3'(src);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_log(input int target, input string tag);
    int t = 0;
    while (log_n < target && t < 500) begin
      @(negedge clk);
      t++;
    end
    if (log_n < target) chk({tag, " timeout"}, log_n, target);
    repeat (2) @(negedge clk);
  endtask

  task automatic run_cfg(input int src, input bit word, input bit dec, input logic [23:0] mar0,
                         input logic [7:0] io, input int n, input int waits);
    logic [23:0] ioa, mema, ra, wa, rd;
    logic [15:0] msk;
    bit inb;
    wait_n = waits; wcnt = 0; log_n = 0;
    inb = (src < 2);
    msk = word ? 16'hFFFF : 16'h00FF;
    cfg_write(2'd0, mar0);
    cfg_write(2'd1, {16'd0, io});
    cfg_write(2'd2, 24'(n));
    cfg_write(2'd3, {16'd0, 1'b1, 2'b00, 3'(src), dec, word});
    pulse_req((src + 1) % 8);
    repeat (8) @(negedge clk);
    chk("R9 foreign source ignored", log_n, 0);
    for (int k = 0; k < n; k++) begin
      pulse_req(src);
      wait_log(2 * (k + 1), "R4 transfer");
    end
    ioa = {16'hFFFF, io};
    for (int k = 0; k < n; k++) begin
      mema = exp_mem(mar0, k, dec, word);
      ra = inb ? ioa : mema;
      wa = inb ? mema : ioa;
      chk("R6 read first", {31'd0, log_we[2*k]}, 0);
      chk("R5 read address", log_addr[2*k], ra);
      chk("R6 write second", {31'd0, log_we[2*k+1]}, 1);
      chk("R5 write address", log_addr[2*k+1], wa);
      chk("R6 R1 write data", log_data[2*k+1], fdat(ra) & msk);
      chk("R1 size", {30'd0, log_word[2*k], log_word[2*k+1]}, {30'd0, word, word});
    end
    cfg_read(2'd2, rd); chk("R4 count zero", rd, 0);
    cfg_read(2'd3, rd); chk("R7 enable cleared, irq set", {30'd0, rd[8], rd[7]}, 32'd2);
    chk("R7 irq port", {31'd0, irq}, 1);
    cfg_read(2'd0, rd); chk("R2 final pointer", rd, exp_mem(mar0, n, dec, word));
    cfg_read(2'd1, rd); chk("R3 offset held", rd, {16'd0, io});
    pulse_req(src);
    repeat (10) @(negedge clk);
    chk("R7 request after end ignored", log_n, 2 * n);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog act=running exp=done");
    summary();
  end

  initial begin
    logic [23:0] rd;
    logic [15:0] wd;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    for (int s = 0; s < 4; s++) begin
      cfg_read(2'(s), rd);
      chk("R11 register reset", rd, 0);
    end
    chk("R11 no bus request", {31'd0, bus_req}, 0);
    chk("R11 irq low", {31'd0, irq}, 0);

    // Near-exhaustive sweep: every source, size and step direction
    for (int src = 0; src < 8; src++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 2; d++)
          run_cfg(src, w[0], d[0],
                  d[0] ? 24'(1 + src) : 24'(24'hFFFFFD - src),
                  8'(8'h40 + 3 * src), 2 + (src % 3), src % 3);

    // R8 request during a stalled transfer is held pending
    wait_n = 4; wcnt = 0; log_n = 0;
    cfg_write(2'd0, 24'h002000);
    cfg_write(2'd1, 24'h000010);
    cfg_write(2'd2, 24'd2);
    cfg_write(2'd3, {16'd0, 1'b1, 2'b00, 3'd1, 1'b0, 1'b1});
    pulse_req(1);
    repeat (2) @(negedge clk);
    pulse_req(1);
    wait_log(4, "R8 pending");
    chk("R8 both transfers served", log_n, 4);
    chk("R8 second write address", log_addr[3], 24'h002002);
    chk("R8 irq after pending", {31'd0, irq}, 1);

    // R10 pointer write in the same cycle as transfer completion
    auto_resp = 0; log_n = 0;
    cfg_write(2'd0, 24'h000100);
    cfg_write(2'd1, 24'h000022);
    cfg_write(2'd2, 24'd2);
    cfg_write(2'd3, {16'd0, 1'b1, 2'b00, 3'd4, 1'b0, 1'b0});
    pulse_req(4);
    t = 0;
    while (!bus_req && t < 50) begin @(negedge clk); t++; end
    chk("R10 read address", bus_addr, 24'h000100);
    bus_rdata = 16'h77AB; bus_ack = 1'b1;
    @(negedge clk);
    bus_ack = 1'b0;
    wd = bus_wdata;
    chk("R1 byte data masked", wd, 16'h00AB);
    chk("R5 outbound write to peripheral", bus_addr, 24'hFFFF22);
    bus_ack = 1'b1;
    cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 24'h123456;
    @(negedge clk);
    bus_ack = 1'b0; cfg_we = 1'b0;
    cfg_read(2'd0, rd); chk("R10 software pointer wins", rd, 24'h123456);
    cfg_read(2'd2, rd); chk("R10 count still stepped", rd, 1);
    cfg_read(2'd3, rd); chk("R10 still enabled", {31'd0, rd[7]}, 1);
    wait_n = 0; wcnt = 0; auto_resp = 1;
    pulse_req(4);
    wait_log(2, "R10 follow-up");
    chk("R10 next read uses new pointer", log_addr[0], 24'h123456);
    chk("R7 irq at end", {31'd0, irq}, 1);
    cfg_write(2'd3, 24'd0);
    chk("R7 control write clears irq", {31'd0, irq}, 0);

    summary();
  end
endmodule